// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry

This block is the control state machine of a small stored-program processor. It walks each instruction through up to seven phases: next-address setup, instruction fetch, decode, operand address formation, operand read, data operation and result write. It loads the program counter, the instruction register and the memory address and buffer registers as it goes. A small opcode table sorts every instruction into one of four classes. The class decides which phases run: phases the instruction has no use for are skipped, and the operand address and operand read phases run twice for the two-operand load.

The sequencer reaches a single-port memory through a read strobe, a write strobe and a ready input. Every memory phase waits for ready. It emits a one-cycle ALU enable in the data-operation phase as a hook for a datapath that lies outside this block. When an instruction ends, a latched interrupt request may be taken. This happens only if interrupts are enabled. Taking it costs one interrupt-entry cycle, which saves the return address in a dedicated register, points the program counter at a fixed handler address and clears the enable. A return instruction restores the program counter and sets the enable again.

Top module: `instr_cycle_seq`

## Requirements
- R1: While rst_ni is low: phase_o is 0, pc_o, ir_o and epc_o are zero, int_en_o is low, and both memory strobes are low. Phase codes are: 0 address setup, 1 fetch, 2 decode, 3 operand address, 4 operand read, 5 data operation, 6 result write, 7 interrupt entry.
- R2: The address-setup phase copies pc_o into mem_addr_o and then enters fetch. Fetch holds mem_rd_o high. When mem_ready_i is seen, ir_o takes mem_rdata_i and pc_o increments by one. The instruction word carries a 4-bit opcode in bits [15:12] and the operand or target field in bits [7:0].
- R3: While a memory phase (codes 1, 4 and 6) sees mem_ready_i low, the phase, the strobe, pc_o and ir_o all hold.
- R4: Opcodes 0x0, 0x1, 0x7 and 0x8 to 0xF are register-operate. They run address setup, fetch, decode and data operation (4 cycles with no wait states), with alu_en_o high for exactly one cycle and no operand access.
- R5: Opcode 0x2 loads one operand. It runs operand address (mem_addr_o = field), then an operand read that places the word in the buffer register (mem_wdata_o), then data operation: 6 cycles in all.
- R6: Opcode 0x3 loads two operands. It runs operand address and operand read twice, at field and then field+1, so the buffer ends up holding the second word. It takes 8 cycles.
- R7: Opcode 0x4 stores. Operand address loads the buffer from store_data_i, and result write drives mem_wr_o at address field. There is no data operation and no ALU enable. It takes 5 cycles.
- R8: Opcode 0x5 jumps. Decode loads pc_o with the field, skipping every operand and data phase. It takes 3 cycles.
- R9: A one-cycle pulse on irq_i latches a pending request. If the request is pending and interrupts are enabled when an instruction ends, one interrupt-entry cycle follows. In that cycle int_ack_o is high and int_en_o is still high. On leaving it, epc_o holds the next-instruction address, pc_o equals IVEC and int_en_o is low.
- R10: Opcode 0x7 sets int_en_o in its data operation. Opcode 0x6 (return) restores pc_o from epc_o and sets int_en_o in decode, taking 3 cycles.
- R11: A request that arrives while interrupts are disabled stays pending without changing the instruction flow. It is taken as soon as interrupts are enabled at an instruction end, including directly after a return.
- R12: mem_rd_o and mem_wr_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | Interrupt request, each high cycle latches a pending request |
| mem_ready_i | input | 1 | Memory has completed the strobed access |
| mem_rdata_i | input | DW | Memory read data |
| store_data_i | input | DW | Datapath value written by a store |
| mem_addr_o | output | AW | Memory address register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Memory buffer register (write data, loaded operand) |
| pc_o | output | AW | Program counter |
| ir_o | output | DW | Instruction register |
| epc_o | output | AW | Saved return address |
| phase_o | output | 3 | Current phase code |
| alu_en_o | output | 1 | Data-operation enable for the datapath |
| int_ack_o | output | 1 | High during the interrupt-entry cycle |
| int_en_o | output | 1 | Interrupt enable |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 16-bit word, a 4-bit opcode and the handler at 0xE0. That address range is small enough for the bench memory model to cover all of it. It also keeps the handler well away from both the program at address 0 and the operands around 0x20 to 0x44, so a wrong vector or return address shows up as a wrong fetch. A wait-state setting of three cycles makes every hold path in fetch and operand read observable. The bench then drives the disabled-pending case and the request that is taken straight after a return, which is the tightest ordering in the interrupt logic.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  typedef enum logic [2:0] {
    PH_IAC = 3'd0,
    PH_IF  = 3'd1,
    PH_IOD = 3'd2,
    PH_OAC = 3'd3,
    PH_OF  = 3'd4,
    PH_DO  = 3'd5,
    PH_OS  = 3'd6,
    PH_INT = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    CL_REG   = 2'd0,
    CL_LOAD  = 2'd1,
    CL_STORE = 2'd2,
    CL_CTRL  = 2'd3
  } class_e;

  typedef struct packed {
    class_e cls;
    logic   two_opnd;
    logic   rti;
    logic   set_ie;
  } dec_t;

  localparam int OPC_NOP = 0;
  localparam int OPC_ALU = 1;
  localparam int OPC_LD  = 2;
  localparam int OPC_LD2 = 3;
  localparam int OPC_ST  = 4;
  localparam int OPC_JMP = 5;
  localparam int OPC_RTI = 6;
  localparam int OPC_EI  = 7;

endpackage

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode
  import seq_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] opc_i,
  output dec_t             dec_o
);

  always_comb begin
    dec_o = '{cls: CL_REG, two_opnd: 1'b0, rti: 1'b0, set_ie: 1'b0};
    if (opc_i == OPC_W'(OPC_LD)) begin
      dec_o.cls = CL_LOAD;
    end else if (opc_i == OPC_W'(OPC_LD2)) begin
      dec_o.cls      = CL_LOAD;
      dec_o.two_opnd = 1'b1;
    end else if (opc_i == OPC_W'(OPC_ST)) begin
      dec_o.cls = CL_STORE;
    end else if (opc_i == OPC_W'(OPC_JMP)) begin
      dec_o.cls = CL_CTRL;
    end else if (opc_i == OPC_W'(OPC_RTI)) begin
      dec_o.cls = CL_CTRL;
      dec_o.rti = 1'b1;
    end else if (opc_i == OPC_W'(OPC_EI)) begin
      dec_o.set_ie = 1'b1;
    end
  end

endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
  import seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   mem_ready_i,
  input  class_e cls_i,
  input  logic   two_opnd_i,
  input  logic   int_go_i,
  output phase_e phase_o,
  output logic   idx_o
);

  phase_e phase_q, phase_d, end_ph;
  logic   idx_q, idx_d;

  // next phase once an instruction has finished
  assign end_ph = int_go_i ? PH_INT : PH_IAC;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_IAC: phase_d = PH_IF;
      PH_IF:  if (mem_ready_i) phase_d = PH_IOD;
      PH_IOD: begin
        idx_d = 1'b0;
        unique case (cls_i)
          CL_REG:            phase_d = PH_DO;
          CL_LOAD, CL_STORE: phase_d = PH_OAC;
          default:           phase_d = end_ph;
        endcase
      end
      PH_OAC: phase_d = (cls_i == CL_STORE) ? PH_OS : PH_OF;
      PH_OF: begin
        if (mem_ready_i) begin
          if (two_opnd_i && !idx_q) begin
            idx_d   = 1'b1;
            phase_d = PH_OAC;
          end else begin
            phase_d = PH_DO;
          end
        end
      end
      PH_DO:  phase_d = end_ph;
      PH_OS:  if (mem_ready_i) phase_d = end_ph;
      PH_INT: phase_d = PH_IAC;
      default: phase_d = PH_IAC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IAC;
      idx_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/seq_pcu.sv
`timescale 1ns/1ps
module seq_pcu
  import seq_pkg::*;
#(
  parameter int              AW   = 8,
  parameter logic [AW-1:0]   IVEC = 'hE0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          is_ctrl_i,
  input  logic          is_rti_i,
  input  logic          set_ie_i,
  input  logic [AW-1:0] field_i,
  input  logic          mem_ready_i,
  input  logic          irq_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] epc_o,
  output logic          ie_o,
  output logic          int_go_o
);

  logic [AW-1:0] pc_q, epc_q;
  logic          ie_q, pend_q, ie_set;

  assign ie_set   = (phase_i == PH_IOD && is_rti_i) || (phase_i == PH_DO && set_ie_i);
  // enable as it will stand after this cycle, so a return can be followed at once
  assign int_go_o = pend_q && (ie_q || ie_set);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      epc_q  <= '0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= irq_i || (pend_q && phase_i != PH_INT);
      if (ie_set) ie_q <= 1'b1;
      unique case (phase_i)
        PH_IF:  if (mem_ready_i) pc_q <= pc_q + AW'(1);
        PH_IOD: if (is_ctrl_i) pc_q <= is_rti_i ? epc_q : field_i;
        PH_INT: begin
          epc_q <= pc_q;
          pc_q  <= IVEC;
          ie_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign pc_o  = pc_q;
  assign epc_o = epc_q;
  assign ie_o  = ie_q;

endmodule

// File: rtl/seq_memif.sv
`timescale 1ns/1ps
module seq_memif
  import seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          is_store_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] field_i,
  input  logic          idx_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] store_data_i,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mbr_o,
  output logic [DW-1:0] ir_o,
  output logic          rd_o,
  output logic          wr_o
);

  logic [AW-1:0] mar_q;
  logic [DW-1:0] mbr_q, ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      unique case (phase_i)
        PH_IAC: mar_q <= pc_i;
        PH_IF:  if (mem_ready_i) ir_q <= mem_rdata_i;
        PH_OAC: begin
          mar_q <= field_i + AW'(idx_i);
          if (is_store_i) mbr_q <= store_data_i;
        end
        PH_OF:  if (mem_ready_i) mbr_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign rd_o  = (phase_i == PH_IF) || (phase_i == PH_OF);
  assign wr_o  = (phase_i == PH_OS);
  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;

endmodule

// File: rtl/instr_cycle_seq.sv
`timescale 1ns/1ps
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int            AW    = 8,
  parameter int            DW    = 16,
  parameter int            OPC_W = 4,
  parameter logic [AW-1:0] IVEC  = 'hE0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] store_data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [AW-1:0] epc_o,
  output logic [2:0]    phase_o,
  output logic          alu_en_o,
  output logic          int_ack_o,
  output logic          int_en_o
);

  localparam int OPC_LSB = DW - OPC_W;

  phase_e        phase;
  dec_t          dec;
  logic          idx, int_go;
  logic [DW-1:0] ir;
  logic [AW-1:0] field, pc;

  assign field = ir[AW-1:0];

  seq_decode #(.OPC_W(OPC_W)) i_decode (
    .opc_i (ir[DW-1:OPC_LSB]),
    .dec_o (dec)
  );

  seq_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_ready_i (mem_ready_i),
    .cls_i       (dec.cls),
    .two_opnd_i  (dec.two_opnd),
    .int_go_i    (int_go),
    .phase_o     (phase),
    .idx_o       (idx)
  );

  seq_pcu #(.AW(AW), .IVEC(IVEC)) i_pcu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .is_ctrl_i   (dec.cls == CL_CTRL),
    .is_rti_i    (dec.rti),
    .set_ie_i    (dec.set_ie),
    .field_i     (field),
    .mem_ready_i (mem_ready_i),
    .irq_i       (irq_i),
    .pc_o        (pc),
    .epc_o       (epc_o),
    .ie_o        (int_en_o),
    .int_go_o    (int_go)
  );

  seq_memif #(.AW(AW), .DW(DW)) i_memif (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase),
    .is_store_i   (dec.cls == CL_STORE),
    .pc_i         (pc),
    .field_i      (field),
    .idx_i        (idx),
    .mem_ready_i  (mem_ready_i),
    .mem_rdata_i  (mem_rdata_i),
    .store_data_i (store_data_i),
    .mar_o        (mem_addr_o),
    .mbr_o        (mem_wdata_o),
    .ir_o         (ir),
    .rd_o         (mem_rd_o),
    .wr_o         (mem_wr_o)
  );

  assign pc_o      = pc;
  assign ir_o      = ir;
  assign phase_o   = phase;
  assign alu_en_o  = (phase == PH_DO);
  assign int_ack_o = (phase == PH_INT);

endmodule

// File: rtl/seq_checker.sv
`timescale 1ns/1ps
module seq_checker #(
  parameter int            AW   = 8,
  parameter int            DW   = 16,
  parameter logic [AW-1:0] IVEC = 'hE0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_ready_i,
  input logic [DW-1:0] mem_rdata_i,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [2:0]    phase_o,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] ir_o,
  input logic [AW-1:0] epc_o,
  input logic          alu_en_o,
  input logic          int_ack_o,
  input logic          int_en_o
);

  p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_hold_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) && !mem_ready_i |=>
      $stable(phase_o) && $stable(pc_o) && $stable(ir_o));

  p_fetch_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd1 && mem_ready_i |=>
      pc_o == $past(pc_o) + AW'(1) && ir_o == $past(mem_rdata_i));

  p_int_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_o |=> pc_o == IVEC && !int_en_o && epc_o == $past(pc_o) && phase_o == 3'd0);

  p_ack_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_o |-> int_en_o);

  p_alu_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_en_o |=> !alu_en_o);

endmodule

bind instr_cycle_seq seq_checker #(.AW(AW), .DW(DW), .IVEC(IVEC)) i_seq_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_ready_i (mem_ready_i),
  .mem_rdata_i (mem_rdata_i),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .phase_o     (phase_o),
  .pc_o        (pc_o),
  .ir_o        (ir_o),
  .epc_o       (epc_o),
  .alu_en_o    (alu_en_o),
  .int_ack_o   (int_ack_o),
  .int_en_o    (int_en_o)
);

// File: tb/test_instr_cycle_seq.sv
`timescale 1ns/1ps
module test_instr_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 1'b0;
  logic        mem_ready_i;
  logic [15:0] mem_rdata_i;
  logic [15:0] store_data_i = '0;
  logic [7:0]  mem_addr_o, pc_o, epc_o;
  logic        mem_rd_o, mem_wr_o, alu_en_o, int_ack_o, int_en_o;
  logic [15:0] mem_wdata_o, ir_o;
  logic [2:0]  phase_o;

  logic [15:0] mem [256];
  int          wait_n = 0;
  logic [3:0]  wcnt = '0;
  int          checks = 0;
  int          errors = 0;
  int          both_cnt = 0;

  always #2 clk = ~clk;

  assign mem_rdata_i = mem[mem_addr_o];
  assign mem_ready_i = (int'(wcnt) >= wait_n);

  always @(posedge clk) begin
    if ((mem_rd_o || mem_wr_o) && !mem_ready_i) wcnt <= wcnt + 4'd1;
    else wcnt <= '0;
  end

  instr_cycle_seq i_instr_cycle_seq (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i), .store_data_i(store_data_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .pc_o(pc_o), .ir_o(ir_o), .epc_o(epc_o),
    .phase_o(phase_o), .alu_en_o(alu_en_o), .int_ack_o(int_ack_o), .int_en_o(int_en_o)
  );

  typedef struct packed {
    int          req;
    logic [3:0]  opc;
    logic [7:0]  fld;
    logic [15:0] sdat;
    int          cyc;
    logic [7:0]  pc;
    logic [15:0] mbr;
    int          alu;
    int          wr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4, 4'h1, 8'h20, 16'h0000, 4, 8'h01, 16'h0000, 1, 0},  // R4 operate
    '{5, 4'h2, 8'h20, 16'h0000, 6, 8'h01, 16'h5A20, 1, 0},  // R5 load
    '{6, 4'h3, 8'h20, 16'h0000, 8, 8'h01, 16'h5A21, 1, 0},  // R6 two-operand load
    '{7, 4'h4, 8'h30, 16'hBEEF, 5, 8'h01, 16'hBEEF, 0, 1},  // R7 store
    '{8, 4'h5, 8'h44, 16'h0000, 3, 8'h44, 16'h0000, 0, 0},  // R8 jump
    '{4, 4'h0, 8'h10, 16'h0000, 4, 8'h01, 16'h0000, 1, 0},  // R4 no-op
    '{4, 4'hF, 8'h7F, 16'h0000, 4, 8'h01, 16'h0000, 1, 0}   // R4 unassigned opcode
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 16'h5A00 | 16'(i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    irq_i  = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // runs from the current point until address setup is seen again
  task automatic run_instr(input logic pulse, output int cyc, output int alu,
                           output int wr, output int rd, output int ack);
    cyc = 0; alu = 0; wr = 0; rd = 0; ack = 0;
    irq_i = pulse;
    do begin
      @(negedge clk);
      irq_i = 1'b0;
      cyc++;
      alu += int'(alu_en_o);
      wr  += int'(mem_wr_o);
      rd  += int'(mem_rd_o);
      ack += int'(int_ack_o);
      if (mem_rd_o && mem_wr_o) both_cnt++;
      if (mem_wr_o && mem_ready_i) mem[mem_addr_o] = mem_wdata_o;
    end while (phase_o != 3'd0 && cyc < 200);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, alu, wr, rd, ack;

    // table walk: one instruction per vector
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      fill();
      mem[0] = {VECS[v].opc, 4'h0, VECS[v].fld};
      store_data_i = VECS[v].sdat;
      do_reset();
      run_instr(1'b0, cyc, alu, wr, rd, ack);
      chk({tag, " cycles"}, cyc, VECS[v].cyc);
      chk({tag, " pc"}, pc_o, VECS[v].pc);
      chk({tag, " R2 ir"}, ir_o, {VECS[v].opc, 4'h0, VECS[v].fld});
      chk({tag, " buffer"}, mem_wdata_o, VECS[v].mbr);
      chk({tag, " alu pulses"}, alu, VECS[v].alu);
      chk({tag, " write cycles"}, wr, VECS[v].wr);
      if (VECS[v].wr != 0) chk({tag, " stored word"}, mem[VECS[v].fld], VECS[v].sdat);
    end
    store_data_i = '0;

    // R3: wait states hold fetch, then operand read
    fill();
    mem[0] = 16'h2020;
    wait_n = 3;
    do_reset();
    @(negedge clk);
    @(negedge clk);
    chk("R3 phase held in fetch", phase_o, 3'd1);
    chk("R3 read strobe held", mem_rd_o, 1'b1);
    chk("R3 ir unchanged", ir_o, 16'h0000);
    chk("R3 pc unchanged", pc_o, 8'h00);
    run_instr(1'b0, cyc, alu, wr, rd, ack);
    chk("R3 remaining cycles", cyc, 10);
    chk("R3 remaining read cycles", rd, 6);
    chk("R3 loaded operand", mem_wdata_o, 16'h5A20);
    chk("R3 ir after wait", ir_o, 16'h2020);
    wait_n = 0;

    // R11: request while disabled after reset is not taken
    fill();
    mem[0] = 16'h1000;
    do_reset();
    chk("R1 enable low after reset", int_en_o, 1'b0);
    run_instr(1'b1, cyc, alu, wr, rd, ack);
    chk("R11 disabled request not taken", ack, 0);
    chk("R11 flow unchanged", cyc, 4);

    // interrupt sequence
    fill();
    mem[0]     = 16'h7000;
    mem[1]     = 16'h1000;
    mem[8'hE0] = 16'h1000;
    mem[8'hE1] = 16'h6000;
    do_reset();
    run_instr(1'b0, cyc, alu, wr, rd, ack);
    chk("R10 enable set by opcode 7", int_en_o, 1'b1);
    run_instr(1'b1, cyc, alu, wr, rd, ack);
    chk("R9 cycles with entry", cyc, 5);
    chk("R9 ack count", ack, 1);
    chk("R9 pc at vector", pc_o, 8'hE0);
    chk("R9 return address", epc_o, 8'h02);
    chk("R9 enable cleared", int_en_o, 1'b0);
    run_instr(1'b1, cyc, alu, wr, rd, ack);
    chk("R11 held while in handler", ack, 0);
    chk("R11 handler flow", cyc, 4);
    chk("R11 handler pc", pc_o, 8'hE1);
    run_instr(1'b0, cyc, alu, wr, rd, ack);
    chk("R11 taken after return", ack, 1);
    chk("R11 return plus entry cycles", cyc, 4);
    chk("R11 pc vectored again", pc_o, 8'hE0);
    chk("R11 return address kept", epc_o, 8'h02);
    run_instr(1'b0, cyc, alu, wr, rd, ack);
    run_instr(1'b0, cyc, alu, wr, rd, ack);
    chk("R10 return cycles", cyc, 3);
    chk("R10 return pc", pc_o, 8'h02);
    chk("R10 return enables", int_en_o, 1'b1);
    chk("R12 no overlapping strobes", both_cnt, 0);

    // R1: asynchronous reset in mid-program
    @(negedge clk);
    @(negedge clk);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 phase", phase_o, 3'd0);
    chk("R1 pc", pc_o, 8'h00);
    chk("R1 ir", ir_o, 16'h0000);
    chk("R1 epc", epc_o, 8'h00);
    chk("R1 enable", int_en_o, 1'b0);
    chk("R1 strobes", {mem_rd_o, mem_wr_o}, 2'b00);
    rst_ni = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule